// File: doc/BRIEF.md
# Indirect Serial Flash Read Sequencer

This block carries out one programmed read from a serial NOR flash and places the returned bytes in a receive queue for a host to drain. It latches a transfer description when a launch pulse arrives. It then drives chip-select and the serial clock through every phase of the read. The phases are a command byte, between one and four address bytes, an optional mode byte, a run of idle turnaround clocks, and finally the data. Data can come back on one, two or four lanes. The command, address and mode bytes always go out on lane 0.

Each received byte becomes one queue word. The host reads the queue fill level and pops words through a simple read port. When the queue fills, the sequencer holds the serial clock low until a word is popped, so no data is lost. A pulse on the abort input ends a transfer early. Normal completion raises a sticky completion flag, which the host clears by pulsing a clear input.

Top module: `qrd_seq`

## Requirements
- R1: After a launch, chip-select goes low and lane 0 (`dq_oe` = 4'b0001) carries the 8-bit command, then `cfg_addr_size`+1 address bytes taken from the low end of `cfg_start_addr`. All of these go out MSB first, one bit per serial clock, and the device samples them on the rising edge.
- R2: When `cfg_mode_en` is 1, the 8-bit `cfg_mode_val` is sent MSB first on lane 0 directly after the last address byte. When it is 0, no mode clocks occur.
- R3: After the command bytes, exactly `cfg_dummy` (0 to 31) serial clocks run with no lane driven, before the data. The mode byte clocks are not counted in this number.
- R4: The data lane code `cfg_data_lanes` is 0 for one lane, 1 for two lanes and 2 for four lanes. With one lane, each clock samples one bit from `dq_in[1]`. With two lanes, each clock samples `dq_in[1:0]`, and `dq_in[1]` holds the more significant bit. With four lanes, each clock samples `dq_in[3:0]` as a nibble. In every case, the earliest sample is the most significant part of the byte, so a byte takes 8, 4 or 2 clocks.
- R5: Received bytes leave `rx_data` in arrival order. `rx_level` counts the words held. A pulse on `rx_pop` with a non-empty queue removes the head word.
- R6: When the queue is full at the start of a data byte, `sclk` stays low and no clock is issued until a word is popped. The transfer then resumes with no byte lost.
- R7: After `cfg_byte_count` bytes are received, chip-select goes high, `stat_busy` falls and `stat_done` rises. A count of zero ends the transfer right after the turnaround clocks.
- R8: `stat_done` stays set until `ctl_done_clr` is pulsed, and then reads 0 on the following cycle.
- R9: A launch pulse while idle sets `stat_busy` on the next cycle. A launch pulse while busy has no effect on the transfer in progress.
- R10: A pulse on `ctl_cancel` raises chip-select, clears `stat_busy` and empties the queue on the next cycle, and it leaves `stat_done` unset.
- R11: After reset, chip-select is high, `sclk` is low, no lane is driven, `stat_busy` and `stat_done` are 0, and `rx_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_opcode | input | 8 | Read command byte |
| cfg_data_lanes | input | 2 | Data phase lane code (0/1/2) |
| cfg_mode_en | input | 1 | Send mode byte after the address |
| cfg_mode_val | input | 8 | Mode byte value |
| cfg_dummy | input | 5 | Turnaround clock count |
| cfg_addr_size | input | 2 | Address bytes minus one |
| cfg_start_addr | input | 32 | Flash start address |
| cfg_byte_count | input | BCNT_W | Bytes to receive |
| ctl_start | input | 1 | Launch pulse |
| ctl_cancel | input | 1 | Abort pulse, also empties the queue |
| ctl_done_clr | input | 1 | Clears the completion flag |
| stat_busy | output | 1 | Transfer in progress |
| stat_done | output | 1 | Sticky completion flag |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip-select, active low |
| dq_out | output | 4 | Lane output values |
| dq_oe | output | 4 | Lane output enables |
| dq_in | input | 4 | Lane input values |
| rx_level | output | LEVEL_W | Queue fill in words |
| rx_pop | input | 1 | Pop the head word |
| rx_data | output | 8 | Head word of the queue |

## Verification
The bench builds the block with a queue depth of 4 instead of the default 16. A ten-byte read therefore fills the queue partway through, and the bench can observe the clock stall and its release. With the same depth, an abort can land while the queue holds data, so the flush has something to remove. The byte counter keeps its default 16-bit width. Zero-length, one-lane, two-lane and four-lane reads, with and without a mode byte, cover every phase path of the sequencer.

// File: rtl/qrd_pkg.sv
package qrd_pkg;

    localparam int DUMMY_W = 5;

    typedef enum logic [1:0] {
        LN_X1 = 2'd0,
        LN_X2 = 2'd1,
        LN_X4 = 2'd2
    } lane_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_DATA
    } phase_e;

    typedef struct packed {
        lane_e               lanes;
        logic                mode_en;
        logic [7:0]          mode_val;
        logic [DUMMY_W-1:0]  dummy;
        logic [1:0]          addr_size;
        logic [31:0]         addr;
    } xfer_cfg_t;

    // serial clocks needed for one data byte
    function automatic logic [3:0] clks_per_byte(lane_e l);
        case (l)
            LN_X2:   return 4'd4;
            LN_X4:   return 4'd2;
            default: return 4'd8;
        endcase
    endfunction

    // left-justify the address bytes that will be sent
    function automatic logic [31:0] align_addr(logic [31:0] a, logic [1:0] sz);
        case (sz)
            2'd0:    return {a[7:0], 24'b0};
            2'd1:    return {a[15:0], 16'b0};
            2'd2:    return {a[23:0], 8'b0};
            default: return a;
        endcase
    endfunction

endpackage

// File: rtl/qrd_rx_fifo.sv
module qrd_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic [CW-1:0] level,
    output logic          full
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign full     = (count == CW'(DEPTH));
    assign do_push  = push && !full;
    assign do_pop   = pop && (count != '0);
    assign pop_data = mem[rd_ptr];
    assign level    = count;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/qrd_rx_assemble.sv
module qrd_rx_assemble
    import qrd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sample,
    input  lane_e      lanes,
    input  logic [3:0] dq_in,
    output logic [7:0] byte_nxt
);
    logic [7:0] sr;

    // byte value including the bits sampled this cycle
    always_comb begin
        case (lanes)
            LN_X4:   byte_nxt = {sr[3:0], dq_in};
            LN_X2:   byte_nxt = {sr[5:0], dq_in[1:0]};
            default: byte_nxt = {sr[6:0], dq_in[1]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         sr <= '0;
        else if (sample) sr <= byte_nxt;
    end
endmodule

// File: rtl/qrd_seq_ctrl.sv
module qrd_seq_ctrl
    import qrd_pkg::*;
#(
    parameter int BCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cancel,
    input  logic              done_clr,
    input  xfer_cfg_t         cfg_in,
    input  logic [7:0]        opcode,
    input  logic [BCNT_W-1:0] byte_count,
    input  logic              fifo_full,
    output logic              sclk,
    output logic              cs_n,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    output logic              sample,
    output logic              push,
    output lane_e             lanes,
    output logic              busy,
    output logic              done,
    output logic              in_data
);
    phase_e            phase, nx_phase;
    xfer_cfg_t         cfg;
    logic              half;
    logic [5:0]        cnt, nx_cnt;
    logic [31:0]       tx_sr, nx_tx;
    logic [BCNT_W-1:0] left, nx_left;
    logic [3:0]        cpb;
    logic              stall, step, fin, to_post, to_data, cmd_ph;

    assign cpb    = clks_per_byte(cfg.lanes);
    assign busy   = (phase != PH_IDLE);
    assign stall  = (phase == PH_DATA) && !half && (cnt == 6'(cpb)) && fifo_full;
    assign step   = busy && !stall;
    assign cmd_ph = (phase == PH_OPC) || (phase == PH_ADDR) || (phase == PH_MODE);

    // next phase at the last clock of the current one
    always_comb begin
        nx_phase = phase;
        nx_cnt   = cnt - 6'd1;
        nx_tx    = {tx_sr[30:0], 1'b0};
        nx_left  = left;
        fin      = 1'b0;
        to_post  = 1'b0;
        to_data  = 1'b0;
        if (half && cnt == 6'd1) begin
            case (phase)
                PH_OPC: begin
                    nx_phase = PH_ADDR;
                    nx_cnt   = (6'(cfg.addr_size) + 6'd1) << 3;
                    nx_tx    = align_addr(cfg.addr, cfg.addr_size);
                end
                PH_ADDR: begin
                    if (cfg.mode_en) begin
                        nx_phase = PH_MODE;
                        nx_cnt   = 6'd8;
                        nx_tx    = {cfg.mode_val, 24'b0};
                    end else begin
                        to_post = 1'b1;
                    end
                end
                PH_MODE:  to_post = 1'b1;
                PH_DUMMY: to_data = 1'b1;
                PH_DATA: begin
                    nx_left = left - BCNT_W'(1);
                    if (left == BCNT_W'(1)) fin = 1'b1;
                    else                    nx_cnt = 6'(cpb);
                end
                default: ;
            endcase
        end
        if (to_post) begin
            if (cfg.dummy != '0) begin
                nx_phase = PH_DUMMY;
                nx_cnt   = 6'(cfg.dummy);
            end else begin
                to_data = 1'b1;
            end
        end
        if (to_data) begin
            if (left == '0) begin
                fin = 1'b1;
            end else begin
                nx_phase = PH_DATA;
                nx_cnt   = 6'(cpb);
            end
        end
        if (fin) nx_phase = PH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            half  <= 1'b0;
            cnt   <= '0;
            tx_sr <= '0;
            left  <= '0;
            cfg   <= '0;
        end else if (cancel) begin
            phase <= PH_IDLE;
            half  <= 1'b0;
        end else if (phase == PH_IDLE) begin
            if (start) begin
                cfg   <= cfg_in;
                tx_sr <= {opcode, 24'b0};
                cnt   <= 6'd8;
                half  <= 1'b0;
                left  <= byte_count;
                phase <= PH_OPC;
            end
        end else if (step) begin
            half <= !half;
            if (half) begin
                phase <= nx_phase;
                cnt   <= nx_cnt;
                tx_sr <= nx_tx;
                left  <= nx_left;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                               done <= 1'b0;
        else if (step && half && fin && !cancel) done <= 1'b1;
        else if (done_clr)                     done <= 1'b0;
    end

    assign sclk    = busy && half;
    assign cs_n    = !busy;
    assign dq_oe   = {3'b000, cmd_ph};
    assign dq_out  = {3'b000, cmd_ph && tx_sr[31]};
    assign sample  = step && half && (phase == PH_DATA);
    assign push    = sample && (cnt == 6'd1);
    assign lanes   = cfg.lanes;
    assign in_data = (phase == PH_DATA);
endmodule

// File: rtl/qrd_seq.sv
module qrd_seq
    import qrd_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int BCNT_W     = 16,
    parameter int LEVEL_W    = 16,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         cfg_opcode,
    input  logic [1:0]         cfg_data_lanes,
    input  logic               cfg_mode_en,
    input  logic [7:0]         cfg_mode_val,
    input  logic [DUMMY_W-1:0] cfg_dummy,
    input  logic [1:0]         cfg_addr_size,
    input  logic [31:0]        cfg_start_addr,
    input  logic [BCNT_W-1:0]  cfg_byte_count,
    input  logic               ctl_start,
    input  logic               ctl_cancel,
    input  logic               ctl_done_clr,
    output logic               stat_busy,
    output logic               stat_done,
    output logic               sclk,
    output logic               cs_n,
    output logic [3:0]         dq_out,
    output logic [3:0]         dq_oe,
    input  logic [3:0]         dq_in,
    output logic [LEVEL_W-1:0] rx_level,
    input  logic               rx_pop,
    output logic [7:0]         rx_data
);
    xfer_cfg_t     cfg_in;
    lane_e         lanes;
    logic          rx_sample, rx_push, rx_full, data_phase;
    logic [7:0]    rx_byte;
    logic [CW-1:0] fifo_level;

    always_comb begin
        cfg_in.lanes     = lane_e'(cfg_data_lanes);
        cfg_in.mode_en   = cfg_mode_en;
        cfg_in.mode_val  = cfg_mode_val;
        cfg_in.dummy     = cfg_dummy;
        cfg_in.addr_size = cfg_addr_size;
        cfg_in.addr      = cfg_start_addr;
    end

    qrd_seq_ctrl #(.BCNT_W(BCNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (ctl_start),
        .cancel     (ctl_cancel),
        .done_clr   (ctl_done_clr),
        .cfg_in     (cfg_in),
        .opcode     (cfg_opcode),
        .byte_count (cfg_byte_count),
        .fifo_full  (rx_full),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe),
        .sample     (rx_sample),
        .push       (rx_push),
        .lanes      (lanes),
        .busy       (stat_busy),
        .done       (stat_done),
        .in_data    (data_phase)
    );

    qrd_rx_assemble u_asm (
        .clk      (clk),
        .rst      (rst),
        .sample   (rx_sample),
        .lanes    (lanes),
        .dq_in    (dq_in),
        .byte_nxt (rx_byte)
    );

    qrd_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (ctl_cancel),
        .push      (rx_push),
        .push_data (rx_byte),
        .pop       (rx_pop),
        .pop_data  (rx_data),
        .level     (fifo_level),
        .full      (rx_full)
    );

    assign rx_level = LEVEL_W'(fifo_level);
endmodule

// File: rtl/qrd_seq_chk.sv
module qrd_seq_chk #(
    parameter int FIFO_DEPTH = 16,
    parameter int LEVEL_W    = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               ctl_start,
    input logic               ctl_cancel,
    input logic               ctl_done_clr,
    input logic               stat_busy,
    input logic               stat_done,
    input logic               sclk,
    input logic               cs_n,
    input logic [3:0]         dq_oe,
    input logic [LEVEL_W-1:0] rx_level,
    input logic               rx_push,
    input logic               rx_full,
    input logic               data_phase
);
    a_r6_clock_held_when_full: assert property (@(posedge clk) disable iff (rst)
        (rx_full && data_phase) |-> !sclk);

    a_r6_no_push_into_full: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full);

    a_r10_cancel_releases: assert property (@(posedge clk) disable iff (rst)
        ctl_cancel |=> (cs_n && !stat_busy && rx_level == '0));

    a_r9_start_launches: assert property (@(posedge clk) disable iff (rst)
        (ctl_start && !ctl_cancel && !stat_busy) |=> (stat_busy && !cs_n));

    a_r8_done_clears: assert property (@(posedge clk) disable iff (rst)
        (ctl_done_clr && !stat_busy) |=> !stat_done);

    a_r7_done_ends_transfer: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_done) |-> $past(stat_busy));

    a_r3_no_drive_when_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (dq_oe == 4'b0000));

    a_r5_level_bounded: assert property (@(posedge clk) disable iff (rst)
        rx_level <= LEVEL_W'(FIFO_DEPTH));
endmodule

bind qrd_seq qrd_seq_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LEVEL_W(LEVEL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctl_start    (ctl_start),
    .ctl_cancel   (ctl_cancel),
    .ctl_done_clr (ctl_done_clr),
    .stat_busy    (stat_busy),
    .stat_done    (stat_done),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .dq_oe        (dq_oe),
    .rx_level     (rx_level),
    .rx_push      (rx_push),
    .rx_full      (rx_full),
    .data_phase   (data_phase)
);

// File: tb/sim_qrd_seq.sv
`timescale 1ns/1ps
module sim_qrd_seq;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_opcode = '0;
    logic [1:0]  cfg_data_lanes = '0;
    logic        cfg_mode_en = 1'b0;
    logic [7:0]  cfg_mode_val = '0;
    logic [4:0]  cfg_dummy = '0;
    logic [1:0]  cfg_addr_size = '0;
    logic [31:0] cfg_start_addr = '0;
    logic [15:0] cfg_byte_count = '0;
    logic        ctl_start = 1'b0, ctl_cancel = 1'b0, ctl_done_clr = 1'b0;
    logic        stat_busy, stat_done, sclk, cs_n;
    logic [3:0]  dq_out, dq_oe;
    logic [3:0]  dq_in = '0;
    logic [15:0] rx_level;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_data;

    int errors = 0, checks = 0;

    // flash model state
    int          m_cmd_clks = 64, m_pre = 64, m_k = 1, m_seed = 0;
    int          rises = 0, oe_bad = 0;
    logic [63:0] cmd_cap = '0;

    always #4 clk = ~clk;

    qrd_seq #(.FIFO_DEPTH(DEPTH)) u0 (.*);

    function automatic logic [7:0] pat(int seed, int i);
        return 8'((seed * 37 + i * 29 + 90) & 255);
    endfunction

    always @(posedge sclk or negedge cs_n) begin
        if (sclk) begin
            if (rises < m_cmd_clks) begin
                cmd_cap = {cmd_cap[62:0], dq_out[0]};
                if (dq_oe != 4'b0001) oe_bad++;
            end else if (dq_oe != 4'b0000) begin
                oe_bad++;
            end
            rises++;
        end else begin
            rises   = 0;
            cmd_cap = '0;
            oe_bad  = 0;
        end
    end

    always @(negedge sclk) begin
        int j, bp, off, ch;
        j = rises - m_pre;
        if (j >= 0) begin
            bp  = j * m_k;
            off = bp % 8;
            ch  = (int'(pat(m_seed, bp / 8)) >> (8 - m_k - off)) & ((1 << m_k) - 1);
            case (m_k)
                1:       dq_in = {2'b00, ch[0], 1'b0};
                2:       dq_in = {2'b00, ch[1:0]};
                default: dq_in = ch[3:0];
            endcase
        end
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic setup(int op, int lanes, bit men, int mval, int dmy, int asz,
                         int addr, int n, int seed);
        @(negedge clk);
        cfg_opcode     = 8'(op);
        cfg_data_lanes = 2'(lanes);
        cfg_mode_en    = men;
        cfg_mode_val   = 8'(mval);
        cfg_dummy      = 5'(dmy);
        cfg_addr_size  = 2'(asz);
        cfg_start_addr = 32'(addr);
        cfg_byte_count = 16'(n);
        m_k            = (lanes == 1) ? 2 : (lanes == 2) ? 4 : 1;
        m_cmd_clks     = 8 + 8 * (asz + 1) + (men ? 8 : 0);
        m_pre          = m_cmd_clks + dmy;
        m_seed         = seed;
    endtask

    task automatic pulse_start();
        @(negedge clk) ctl_start = 1'b1;
        @(negedge clk) ctl_start = 1'b0;
    endtask

    task automatic wait_done(string req);
        int g = 0;
        while (!stat_done && g < 5000) begin @(negedge clk); g++; end
        check(stat_done, req, "done never set", 0, 1);
    endtask

    function automatic logic [63:0] exp_cmd(int op, bit men, int mval, int asz, int addr);
        logic [63:0] e = 64'(op & 255);
        for (int i = asz; i >= 0; i--) e = (e << 8) | 64'((addr >> (8 * i)) & 255);
        if (men) e = (e << 8) | 64'(mval & 255);
        return e;
    endfunction

    task automatic drain(string req, int n);
        for (int i = 0; i < n; i++) begin
            check(rx_data == pat(m_seed, i), req, "data byte", rx_data, pat(m_seed, i));
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
        check(rx_level == 0, req, "level after drain", rx_level, 0);
    endtask

    task automatic clear_done();
        @(negedge clk) ctl_done_clr = 1'b1;
        @(negedge clk) ctl_done_clr = 1'b0;
        check(!stat_done, "R8", "done after clear", stat_done, 0);
    endtask

    // full read with command, clock count, data and completion checks
    task automatic t_read(string req, int op, int lanes, bit men, int mval, int dmy,
                          int asz, int addr, int n, int seed);
        setup(op, lanes, men, mval, dmy, asz, addr, n, seed);
        pulse_start();
        check(stat_busy && !cs_n, "R9", "busy after start", stat_busy, 1);
        wait_done("R7");
        check(cmd_cap == exp_cmd(op, men, mval, asz, addr), "R1",
              "command/address bits", cmd_cap, exp_cmd(op, men, mval, asz, addr));
        check(rises == m_pre + n * (8 / m_k), "R3", "sclk count", rises, m_pre + n * (8 / m_k));
        check(oe_bad == 0, "R3", "lane enable pattern", oe_bad, 0);
        check(cs_n && !stat_busy, "R7", "cs released", cs_n, 1);
        check(rx_level == 16'(n), "R5", "level in words", rx_level, n);
        drain(req, n);
        repeat (6) @(negedge clk);
        check(stat_done, "R8", "done sticky", stat_done, 1);
        clear_done();
    endtask

    task automatic t_reset();
        check(cs_n && !sclk && dq_oe == 0, "R11", "pins idle", {cs_n, sclk, dq_oe}, 6'b100000);
        check(!stat_busy && !stat_done, "R11", "status idle", {stat_busy, stat_done}, 0);
        check(rx_level == 0, "R11", "level", rx_level, 0);
    endtask

    task automatic t_stall();
        int g = 0, r0, got = 0;
        setup(8'h0B, 0, 0, 0, 0, 2, 32'h00ABCDEF, 10, 5);
        pulse_start();
        while (rx_level != DEPTH && g < 5000) begin @(negedge clk); g++; end
        r0 = rises;
        repeat (40) begin
            @(negedge clk);
            if (sclk) g = 9999;
        end
        check(g < 5000, "R6", "sclk stayed low while full", g, 0);
        check(rises == r0, "R6", "no clocks while full", rises, r0);
        check(stat_busy, "R6", "still busy while stalled", stat_busy, 1);
        g = 0;
        while (got < 10 && g < 20000) begin
            @(negedge clk);
            rx_pop = 1'b0;
            if (rx_level != 0) begin
                check(rx_data == pat(5, got), "R6", "byte after stall", rx_data, pat(5, got));
                rx_pop = 1'b1;
                got++;
            end
            g++;
        end
        @(negedge clk) rx_pop = 1'b0;
        check(got == 10, "R6", "bytes received", got, 10);
        wait_done("R6");
        clear_done();
    endtask

    task automatic t_cancel();
        int g = 0, r0;
        setup(8'hEB, 2, 1, 8'hA0, 4, 2, 32'h00123456, 8, 9);
        pulse_start();
        while (rx_level != DEPTH && g < 5000) begin @(negedge clk); g++; end
        check(rx_level == DEPTH, "R10", "level before abort", rx_level, DEPTH);
        @(negedge clk) ctl_cancel = 1'b1;
        @(negedge clk) ctl_cancel = 1'b0;
        check(cs_n && !stat_busy, "R10", "released after abort", {cs_n, stat_busy}, 2'b10);
        check(rx_level == 0, "R10", "queue flushed", rx_level, 0);
        r0 = rises;
        repeat (20) @(negedge clk);
        check(!stat_done, "R10", "done not set by abort", stat_done, 0);
        check(rises == r0, "R10", "no clocks after abort", rises, r0);
    endtask

    task automatic t_restart_ignored();
        setup(8'h03, 0, 0, 0, 0, 2, 32'h00C0FFEE, 3, 11);
        pulse_start();
        repeat (10) @(negedge clk);
        cfg_opcode = 8'h77;
        pulse_start();
        wait_done("R9");
        check(cmd_cap == exp_cmd(8'h03, 0, 0, 2, 32'h00C0FFEE), "R9",
              "second launch ignored", cmd_cap, exp_cmd(8'h03, 0, 0, 2, 32'h00C0FFEE));
        check(rises == m_pre + 24, "R9", "clock count unchanged", rises, m_pre + 24);
        drain("R9", 3);
        clear_done();
    endtask

    task automatic t_zero();
        setup(8'h0B, 0, 0, 0, 8, 2, 32'h00000100, 0, 1);
        pulse_start();
        wait_done("R7");
        check(rises == m_pre, "R7", "zero-length clocks", rises, m_pre);
        check(rx_level == 0, "R7", "zero-length level", rx_level, 0);
        clear_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read("R4", 8'h03, 0, 0, 0, 0, 2, 32'h00A1B2C3, 4, 1);
        t_read("R2", 8'hEC, 2, 1, 8'hA5, 8, 3, 32'h89ABCDEF, 4, 2);
        t_read("R4", 8'h3B, 1, 0, 0, 3, 0, 32'h0000005A, 3, 3);
        t_read("R2", 8'h6B, 2, 0, 8'hFF, 0, 1, 32'h00001234, 2, 4);
        t_stall();
        t_cancel();
        t_restart_ignored();
        t_zero();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule